// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This unit sits beside the decoder of a small 16-bit CPU and turns the addressing-mode fields of a two-operand instruction into operand locations. When `start` is pulsed, it captures the source mode (2 bits), the destination mode (1 bit), both register numbers, the byte/word flag, the current program counter and the two named register values. A single encoding can select more than one mode. The register number decides which one applies: register 0 is the program counter and register 2 is the status register.

Some modes need an extension word. For those, the unit raises `ext_req` and waits for `ext_valid`, consuming the source's word first and then the destination's. It then presents one `done` cycle. That cycle carries the operand kinds, the effective addresses, any immediate value and the memory read requests. It also carries the writebacks: one for an autoincremented register and one for the advanced program counter. The register file applies both at that edge, so the next instruction already sees them.

Top module: `oam_unit`

## Requirements
- R1: Mode 0 on either operand is register mode. Its kind is 0 (register), its address output is 0, it raises no read request and it fetches no extension word.
- R2: Mode 01 (source) or 1 (destination) on a register other than 0 or 2 is indexed mode. The kind is 1 (memory), the read request is set, and the address is the register value plus the extension word, modulo 2^16.
- R3: Indexed encoding on register 0 is symbolic mode. The address is the location of that operand's extension word plus the word.
- R4: Indexed encoding on register 2 is absolute mode. The address is the extension word itself.
- R5: Source mode 10 is indirect mode. The kind is memory, the address is the register value, and no extension word is fetched.
- R6: Source mode 11 on a register other than 0 is autoincrement mode. The address is the register value. In the done cycle the unit writes that register back with its value plus 1 for a byte operation or plus 2 for a word operation.
- R7: Source mode 11 on register 0 is immediate mode. The kind is 2 (immediate) and the immediate output carries the extension word. The program counter steps past it by 2 even for a byte operation, and no register autoincrement is issued.
- R8: The source's extension word is consumed before the destination's. `ext_req` stays high until `ext_valid` is seen, and `ext_valid` is ignored while `ext_req` is low. `pc_wr_en` is set in the done cycle exactly when at least one word was consumed, with `pc_wr_val` equal to the captured PC plus 2 per word.
- R9: If the destination is indexed on the same register that the source autoincrements, the destination address uses the incremented value.
- R10: `start` is ignored while `busy` is high. `done` lasts exactly one cycle, after which `busy` is low. All result outputs read 0 outside the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin decoding the presented fields (accepted when idle) |
| src_mode | input | 2 | Source addressing-mode field |
| src_reg | input | 4 | Source register number |
| dst_mode | input | 1 | Destination addressing-mode field |
| dst_reg | input | 4 | Destination register number |
| byte_op | input | 1 | 1 = byte operation, 0 = word operation |
| pc_in | input | 16 | Address of the word following the opcode |
| src_val | input | 16 | Current value of the source register |
| dst_val | input | 16 | Current value of the destination register |
| ext_valid | input | 1 | Extension word present on `ext_word` |
| ext_word | input | 16 | Extension word from the instruction stream |
| busy | output | 1 | Instruction in progress |
| ext_req | output | 1 | Extension word wanted |
| done | output | 1 | Results valid this cycle |
| src_kind | output | 2 | Source kind: 0 register, 1 memory, 2 immediate |
| src_addr | output | 16 | Source effective address |
| src_imm | output | 16 | Immediate operand value |
| src_rd | output | 1 | Source memory read request |
| dst_kind | output | 2 | Destination kind: 0 register, 1 memory |
| dst_addr | output | 16 | Destination effective address |
| dst_rd | output | 1 | Destination memory read request |
| reg_wr_en | output | 1 | Autoincrement writeback enable |
| reg_wr_idx | output | 4 | Autoincrement register number |
| reg_wr_val | output | 16 | Autoincrement new value |
| pc_wr_en | output | 1 | Program counter update enable |
| pc_wr_val | output | 16 | New program counter value |

## Verification
Two of the unit's functions fall into the same done cycle: the source autoincrement writeback and the destination's indexed address computation. When both name one register, the destination must use the incremented value. The bench provokes this with directed cases for both byte and word steps, and random fields then hit the same pairing again. Each result is judged against a bench model of the register file that applies the expected writebacks before the next instruction. Extension-word stalls and stray `ext_valid` pulses are mixed in so that the word ordering and the PC step are checked under uneven arrival.

// File: rtl/oam_pkg.sv
package oam_pkg;
    localparam int OAM_DW = 16;
    localparam int OAM_RW = 4;

    typedef enum logic [1:0] {
        OPK_REG = 2'd0,
        OPK_MEM = 2'd1,
        OPK_IMM = 2'd2
    } opnd_kind_e;

    typedef enum logic [2:0] {
        AM_REG     = 3'd0,
        AM_INDEX   = 3'd1,
        AM_SYMB    = 3'd2,
        AM_ABS     = 3'd3,
        AM_INDIR   = 3'd4,
        AM_AUTOINC = 3'd5,
        AM_IMM     = 3'd6
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SRC_EXT = 2'd1,
        ST_DST_EXT = 2'd2,
        ST_DONE    = 2'd3
    } oam_state_e;

    typedef struct packed {
        oam_state_e          state;
        amode_e              s_cls;
        amode_e              d_cls;
        logic [OAM_RW-1:0]   s_reg;
        logic [OAM_RW-1:0]   d_reg;
        logic                byte_op;
        logic [OAM_DW-1:0]   s_val;
        logic [OAM_DW-1:0]   d_val;
        logic [OAM_DW-1:0]   pc0;
        logic [OAM_DW-1:0]   pc_run;
        logic [OAM_DW-1:0]   s_ext;
        logic [OAM_DW-1:0]   d_ext;
    } oam_regs_t;

    function automatic logic am_needs_ext(amode_e c);
        return (c == AM_INDEX) || (c == AM_SYMB) || (c == AM_ABS) || (c == AM_IMM);
    endfunction

    function automatic opnd_kind_e am_kind(amode_e c);
        if (c == AM_REG)      return OPK_REG;
        else if (c == AM_IMM) return OPK_IMM;
        else                  return OPK_MEM;
    endfunction
endpackage

// File: rtl/oam_mode_decode.sv
module oam_mode_decode
    import oam_pkg::*;
#(
    parameter int MODE_W = 2,
    parameter int REG_W  = 4,
    parameter int PC_IDX = 0,
    parameter int SR_IDX = 2
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [REG_W-1:0]  rnum,
    output amode_e            cls
);
    localparam logic [REG_W-1:0] PC_R = REG_W'(PC_IDX);
    localparam logic [REG_W-1:0] SR_R = REG_W'(SR_IDX);

    logic   is_pc;
    logic   is_sr;
    amode_e idx_cls;

    assign is_pc = (rnum == PC_R);
    assign is_sr = (rnum == SR_R);

    // indexed encoding splits three ways on the register named
    always_comb begin
        if (is_pc)      idx_cls = AM_SYMB;
        else if (is_sr) idx_cls = AM_ABS;
        else            idx_cls = AM_INDEX;
    end

    generate
        if (MODE_W == 2) begin : g_src
            always_comb begin
                unique case (mode)
                    2'b00:   cls = AM_REG;
                    2'b01:   cls = idx_cls;
                    2'b10:   cls = AM_INDIR;
                    default: cls = is_pc ? AM_IMM : AM_AUTOINC;
                endcase
            end
        end else begin : g_dst
            always_comb cls = mode[0] ? idx_cls : AM_REG;
        end
    endgenerate

    always_comb begin
        assert_zero_mode_reg_R1: assert (mode != '0 || cls == AM_REG);
        assert_imm_src_pc_only_R7: assert (cls != AM_IMM || (MODE_W == 2 && is_pc));
    end
endmodule

// File: rtl/oam_ea_calc.sv
module oam_ea_calc
    import oam_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  amode_e            cls,
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] ext,
    input  logic [DATA_W-1:0] ext_pc,
    output logic [DATA_W-1:0] addr
);
    always_comb begin
        unique case (cls)
            AM_INDEX:             addr = base + ext;
            AM_SYMB:              addr = ext_pc + ext;
            AM_ABS:               addr = ext;
            AM_INDIR, AM_AUTOINC: addr = base;
            default:              addr = '0;
        endcase
    end
endmodule

// File: rtl/oam_unit.sv
module oam_unit
    import oam_pkg::*;
#(
    parameter int PC_IDX    = 0,
    parameter int SR_IDX    = 2,
    parameter int WORD_STEP = 2,
    parameter int BYTE_STEP = 1,
    parameter int EXT_STEP  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        src_mode,
    input  logic [OAM_RW-1:0] src_reg,
    input  logic              dst_mode,
    input  logic [OAM_RW-1:0] dst_reg,
    input  logic              byte_op,
    input  logic [OAM_DW-1:0] pc_in,
    input  logic [OAM_DW-1:0] src_val,
    input  logic [OAM_DW-1:0] dst_val,
    input  logic              ext_valid,
    input  logic [OAM_DW-1:0] ext_word,
    output logic              busy,
    output logic              ext_req,
    output logic              done,
    output logic [1:0]        src_kind,
    output logic [OAM_DW-1:0] src_addr,
    output logic [OAM_DW-1:0] src_imm,
    output logic              src_rd,
    output logic [1:0]        dst_kind,
    output logic [OAM_DW-1:0] dst_addr,
    output logic              dst_rd,
    output logic              reg_wr_en,
    output logic [OAM_RW-1:0] reg_wr_idx,
    output logic [OAM_DW-1:0] reg_wr_val,
    output logic              pc_wr_en,
    output logic [OAM_DW-1:0] pc_wr_val
);
    localparam oam_regs_t REGS_RST = '0;
    localparam logic [OAM_DW-1:0] W_INC = OAM_DW'(WORD_STEP);
    localparam logic [OAM_DW-1:0] B_INC = OAM_DW'(BYTE_STEP);
    localparam logic [OAM_DW-1:0] X_INC = OAM_DW'(EXT_STEP);

    oam_regs_t q, d;

    amode_e            s_cls_in, d_cls_in;
    logic [OAM_DW-1:0] s_inc_val, d_base, d_ext_pc, s_ea, d_ea;
    logic              fwd;

    oam_mode_decode #(.MODE_W(2), .REG_W(OAM_RW), .PC_IDX(PC_IDX), .SR_IDX(SR_IDX))
        u_dec_src (.mode(src_mode), .rnum(src_reg), .cls(s_cls_in));

    oam_mode_decode #(.MODE_W(1), .REG_W(OAM_RW), .PC_IDX(PC_IDX), .SR_IDX(SR_IDX))
        u_dec_dst (.mode(dst_mode), .rnum(dst_reg), .cls(d_cls_in));

    // destination base sees the source autoincrement on a shared register
    always_comb begin
        s_inc_val = q.s_val + (q.byte_op ? B_INC : W_INC);
        fwd       = (q.d_cls == AM_INDEX) && (q.s_cls == AM_AUTOINC) && (q.d_reg == q.s_reg);
        d_base    = fwd ? s_inc_val : q.d_val;
        d_ext_pc  = q.pc0 + (am_needs_ext(q.s_cls) ? X_INC : '0);
    end

    oam_ea_calc #(.DATA_W(OAM_DW)) u_ea_src (
        .cls(q.s_cls), .base(q.s_val), .ext(q.s_ext), .ext_pc(q.pc0), .addr(s_ea));

    oam_ea_calc #(.DATA_W(OAM_DW)) u_ea_dst (
        .cls(q.d_cls), .base(d_base), .ext(q.d_ext), .ext_pc(d_ext_pc), .addr(d_ea));

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.s_cls   = s_cls_in;
                    d.d_cls   = d_cls_in;
                    d.s_reg   = src_reg;
                    d.d_reg   = dst_reg;
                    d.byte_op = byte_op;
                    d.s_val   = src_val;
                    d.d_val   = dst_val;
                    d.pc0     = pc_in;
                    d.pc_run  = pc_in;
                    d.s_ext   = '0;
                    d.d_ext   = '0;
                    if (am_needs_ext(s_cls_in))      d.state = ST_SRC_EXT;
                    else if (am_needs_ext(d_cls_in)) d.state = ST_DST_EXT;
                    else                             d.state = ST_DONE;
                end
            end
            ST_SRC_EXT: begin
                if (ext_valid) begin
                    d.s_ext  = ext_word;
                    d.pc_run = q.pc_run + X_INC;
                    d.state  = am_needs_ext(q.d_cls) ? ST_DST_EXT : ST_DONE;
                end
            end
            ST_DST_EXT: begin
                if (ext_valid) begin
                    d.d_ext  = ext_word;
                    d.pc_run = q.pc_run + X_INC;
                    d.state  = ST_DONE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    always_comb begin
        opnd_kind_e sk, dk;
        sk         = am_kind(q.s_cls);
        dk         = am_kind(q.d_cls);
        busy       = (q.state != ST_IDLE);
        ext_req    = (q.state == ST_SRC_EXT) || (q.state == ST_DST_EXT);
        done       = (q.state == ST_DONE);
        src_kind   = done ? sk : OPK_REG;
        src_addr   = done ? s_ea : '0;
        src_imm    = (done && q.s_cls == AM_IMM) ? q.s_ext : '0;
        src_rd     = done && (sk == OPK_MEM);
        dst_kind   = done ? dk : OPK_REG;
        dst_addr   = done ? d_ea : '0;
        dst_rd     = done && (dk == OPK_MEM);
        reg_wr_en  = done && (q.s_cls == AM_AUTOINC);
        reg_wr_idx = reg_wr_en ? q.s_reg : '0;
        reg_wr_val = reg_wr_en ? s_inc_val : '0;
        pc_wr_en   = done && (am_needs_ext(q.s_cls) || am_needs_ext(q.d_cls));
        pc_wr_val  = pc_wr_en ? q.pc_run : '0;
    end

    assert_ext_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && !ext_valid |=> ext_req && $stable(q.pc_run));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && start |=> $stable(q.s_reg) && $stable(q.d_reg) && $stable(q.pc0));

    assert_imm_steps_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done && src_kind == OPK_IMM |-> pc_wr_en && !reg_wr_en);

    assert_autoinc_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> src_rd && reg_wr_idx != OAM_RW'(PC_IDX));
endmodule

// File: tb/oam_unit_test.sv
module oam_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  src_mode = '0;
    logic [3:0]  src_reg = '0;
    logic        dst_mode = 1'b0;
    logic [3:0]  dst_reg = '0;
    logic        byte_op = 1'b0;
    logic [15:0] pc_in = '0, src_val = '0, dst_val = '0;
    logic        ext_valid = 1'b0;
    logic [15:0] ext_word = '0;
    logic        busy, ext_req, done, src_rd, dst_rd, reg_wr_en, pc_wr_en;
    logic [1:0]  src_kind, dst_kind;
    logic [15:0] src_addr, src_imm, dst_addr, reg_wr_val, pc_wr_val;
    logic [3:0]  reg_wr_idx;

    int checks = 0;
    int failures = 0;
    logic [15:0] rf [16];

    always #5 clk = ~clk;

    oam_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_mode(src_mode), .src_reg(src_reg),
        .dst_mode(dst_mode), .dst_reg(dst_reg), .byte_op(byte_op), .pc_in(pc_in),
        .src_val(src_val), .dst_val(dst_val), .ext_valid(ext_valid), .ext_word(ext_word),
        .busy(busy), .ext_req(ext_req), .done(done), .src_kind(src_kind), .src_addr(src_addr),
        .src_imm(src_imm), .src_rd(src_rd), .dst_kind(dst_kind), .dst_addr(dst_addr),
        .dst_rd(dst_rd), .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx),
        .reg_wr_val(reg_wr_val), .pc_wr_en(pc_wr_en), .pc_wr_val(pc_wr_val));

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string src_tag(input logic [1:0] m, input logic [3:0] r);
        if (m == 2'd0) return "R1";
        if (m == 2'd2) return "R5";
        if (m == 2'd1) return (r == 0) ? "R3" : (r == 2) ? "R4" : "R2";
        return (r == 0) ? "R7" : "R6";
    endfunction

    task automatic run_instr(input logic [1:0] sm, input logic [3:0] sr, input logic dm,
                             input logic [3:0] dr, input logic bop, input logic [15:0] xs,
                             input logic [15:0] xd, input int stall, input bit hold);
        logic        ns, nd, ainc, fwd;
        logic [15:0] pc0, sinc, e_sa, e_si, e_da, dbase, dxpc;
        logic [1:0]  e_sk, e_dk;
        int          nacc, guard;
        string       st, dt;
        ns   = (sm == 2'd1) || (sm == 2'd3 && sr == 0);
        nd   = dm;
        ainc = (sm == 2'd3 && sr != 0);
        pc0  = rf[0];
        sinc = rf[sr] + (bop ? 16'd1 : 16'd2);
        st   = src_tag(sm, sr);
        // expected source side
        e_si = '0;
        case (sm)
            2'd0: begin e_sk = 2'd0; e_sa = '0; end
            2'd1: begin
                e_sk = 2'd1;
                e_sa = (sr == 0) ? pc0 + xs : (sr == 2) ? xs : rf[sr] + xs;
            end
            2'd2: begin e_sk = 2'd1; e_sa = rf[sr]; end
            default: begin
                if (sr == 0) begin e_sk = 2'd2; e_sa = '0; e_si = xs; end
                else begin e_sk = 2'd1; e_sa = rf[sr]; end
            end
        endcase
        // expected destination side
        fwd   = ainc && dm && dr == sr && dr != 0 && dr != 2;
        dbase = fwd ? sinc : rf[dr];
        dxpc  = pc0 + (ns ? 16'd2 : 16'd0);
        if (!dm) begin e_dk = 2'd0; e_da = '0; dt = "R1"; end
        else begin
            e_dk = 2'd1;
            if (dr == 0)      begin e_da = dxpc + xd; dt = "R3"; end
            else if (dr == 2) begin e_da = xd; dt = "R4"; end
            else              begin e_da = dbase + xd; dt = fwd ? "R9" : "R2"; end
        end
        // drive
        src_mode = sm; src_reg = sr; dst_mode = dm; dst_reg = dr; byte_op = bop;
        pc_in = rf[0]; src_val = rf[sr]; dst_val = rf[dr]; start = 1'b1;
        @(negedge clk);
        if (!hold) start = 1'b0;
        nacc = 0;
        guard = 0;
        while (!done && guard < 200) begin
            if (hold) begin
                src_mode = 2'($urandom); src_reg = 4'($urandom); dst_reg = 4'($urandom);
                pc_in = 16'($urandom); src_val = 16'($urandom);
            end
            if (ext_req) begin
                if (int'($urandom % 100) < stall) ext_valid = 1'b0;
                else begin
                    ext_valid = 1'b1;
                    ext_word  = (ns && nacc == 0) ? xs : xd;
                    nacc++;
                end
            end else begin
                ext_valid = $urandom % 2 == 0;   // stray, must be ignored (R8)
                ext_word  = 16'($urandom);
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        ext_valid = 1'b0;
        chk("R10", "done reached", 32'(done), 32'd1);
        chk("R8", "words consumed", 32'(nacc), 32'(int'(ns) + int'(nd)));
        chk(st, "src_kind", 32'(src_kind), 32'(e_sk));
        chk(st, "src_addr", 32'(src_addr), 32'(e_sa));
        chk(st, "src_imm", 32'(src_imm), 32'(e_si));
        chk(st, "src_rd", 32'(src_rd), 32'(e_sk == 2'd1));
        chk(dt, "dst_kind", 32'(dst_kind), 32'(e_dk));
        chk(dt, "dst_addr", 32'(dst_addr), 32'(e_da));
        chk(dt, "dst_rd", 32'(dst_rd), 32'(dm));
        chk("R6", "reg_wr_en", 32'(reg_wr_en), 32'(ainc));
        if (ainc) begin
            chk("R6", "reg_wr_idx", 32'(reg_wr_idx), 32'(sr));
            chk("R6", "reg_wr_val", 32'(reg_wr_val), 32'(sinc));
        end
        chk("R8", "pc_wr_en", 32'(pc_wr_en), 32'(ns || nd));
        if (ns || nd)
            chk("R8", "pc_wr_val", 32'(pc_wr_val),
                32'(pc0 + (ns ? 16'd2 : 16'd0) + (nd ? 16'd2 : 16'd0)));
        // bench register file takes the expected writebacks
        if (ainc) rf[sr] = sinc;
        if (ns || nd) rf[0] = pc0 + (ns ? 16'd2 : 16'd0) + (nd ? 16'd2 : 16'd0);
        @(negedge clk);
        chk("R10", "done one cycle", 32'(done), 32'd0);
        chk("R10", "idle after done", 32'(busy), 32'd0);
        chk("R10", "outputs cleared", 32'(src_addr | dst_addr | pc_wr_val), 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        for (int i = 0; i < 16; i++) rf[i] = 16'(i * 16'h0111 + 16'h0100);
        repeat (3) @(negedge clk);
        chk("R10", "reset busy", 32'(busy), 32'd0);
        chk("R8", "reset ext_req", 32'(ext_req), 32'd0);
        chk("R10", "reset done", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        run_instr(2'd0, 4'd5, 1'b0, 4'd6, 1'b0, 16'h0, 16'h0, 0, 0);         // R1
        rf[7] = 16'hFFFE;
        run_instr(2'd1, 4'd7, 1'b1, 4'd7, 1'b0, 16'h0004, 16'h0010, 30, 0); // R2 wrap
        rf[0] = 16'hC000;
        run_instr(2'd1, 4'd0, 1'b1, 4'd0, 1'b0, 16'h0100, 16'h0200, 0, 0);  // R3 both
        run_instr(2'd1, 4'd2, 1'b1, 4'd2, 1'b1, 16'h0230, 16'h0AAA, 50, 0); // R4 both
        run_instr(2'd2, 4'd9, 1'b0, 4'd3, 1'b0, 16'h0, 16'h0, 0, 0);        // R5
        run_instr(2'd3, 4'd4, 1'b0, 4'd1, 1'b1, 16'h0, 16'h0, 0, 0);        // R6 byte
        run_instr(2'd3, 4'd4, 1'b0, 4'd1, 1'b0, 16'h0, 16'h0, 0, 0);        // R6 word
        run_instr(2'd2, 4'd4, 1'b0, 4'd1, 1'b0, 16'h0, 16'h0, 0, 0);        // reads updated R4 value
        run_instr(2'd3, 4'd0, 1'b1, 4'd0, 1'b1, 16'h5A5A, 16'h0008, 0, 0);  // R7 byte imm
        run_instr(2'd3, 4'd8, 1'b1, 4'd8, 1'b0, 16'h0, 16'h0040, 0, 0);     // R9 word
        run_instr(2'd3, 4'd8, 1'b1, 4'd8, 1'b1, 16'h0, 16'hFFFF, 40, 0);    // R9 byte
        run_instr(2'd1, 4'd3, 1'b1, 4'd5, 1'b0, 16'h1111, 16'h2222, 60, 1); // R10 held start
        for (int n = 0; n < 400; n++) begin
            run_instr(2'($urandom), 4'($urandom), 1'($urandom), 4'($urandom),
                      1'($urandom), 16'($urandom), 16'($urandom),
                      int'($urandom % 60), ($urandom % 8) == 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule